// File: doc/BRIEF.md
# Programmable Pacer Clock Divider

This block turns a slow reference strobe into periodic sample-rate ticks for a data converter. The reference runs at 4 MHz, one strobe every 250 ns, and arrives as a single-cycle enable in the system clock domain. A 16-bit control word sets the period. Its prescale field picks a power-of-two predivider. Its low byte holds the divide count N in complemented form, stored as 255 minus N. The output period is N times the predivide ratio, counted in reference strobes. The longest period is 255 × 2^15 strobes.

Software writes the control word and can read it back. Each write restarts both counter stages, so the first tick follows one full period after the write. A run input freezes both counters and blocks all ticks while it is low. A low byte of 0xFF encodes N = 0. This block treats that code as "stopped": it produces no ticks until a valid count is written.

Top module: `pacer_div_top`

## Requirements
- R1: After reset, `ctrl_rdata` reads 16'hF000, so its upper byte is 0xF0 and the prescale and count fields both hold zero. `tick_o` is low.
- R2: After a cycle with `ctrl_we` high, `ctrl_rdata` returns the full 16-bit word written, including bits [15:12].
- R3: The prescale code p sits in bits [11:8]. It gives a predivide ratio of 2^p for p from 2 to 15. Codes 0 and 1 both give a ratio of 1.
- R4: Bits [7:0] hold 255 minus N. The tick period is N × ratio reference strobes, for N from 1 to 255.
- R5: `tick_o` is high for exactly one clock cycle. That cycle is the one right after the clock edge that sampled the strobe completing a period.
- R6: A write clears both counters. The first tick after a write comes once N × ratio strobes have been seen after the write cycle, whatever count was held before. `tick_o` is low in the cycle after a write.
- R7: While `run_en` is low, both counters keep their values, strobes are not counted and `tick_o` stays low. Counting resumes from the held position when `run_en` returns high.
- R8: A low byte of 0xFF (N = 0) inhibits all ticks, for any prescale code.
- R9: Only cycles with `ref_stb` high advance the counters. Clock cycles without a strobe have no effect on the period.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctrl_we | input | 1 | Write strobe for the control word |
| ctrl_wdata | input | 16 | Control word: [11:8] prescale code, [7:0] 255 minus N |
| ctrl_rdata | output | 16 | Control word read-back |
| ref_stb | input | 1 | 4 MHz reference enable, one cycle wide |
| run_en | input | 1 | Counting enable; low holds the counters |
| tick_o | output | 1 | One-cycle pacer tick |

## Verification
The main function is swept over prescale codes 0 to 5 with counts 1, 2, 3 and 5. The bench also runs two extremes: code 15 with N = 1, and code 0 with N = 255. Every strobe index is compared with an arithmetically expected tick position. This separates a wrong predivide exponent, codes 0 and 1 being treated differently, an off-by-one in the reload, and a failure to complement the count. Strobes are spaced three clocks apart, and the tick is also sampled in a strobe-free cycle. This shows that only strobes advance the count and that each tick lasts exactly one cycle. Separate patterns cover four cases: a rewrite in mid-period, which tells a restart from a carried-over count; a stretch with run held low; the N = 0 code; and read-back after reset and after writes.

// File: rtl/pacer_pkg.sv
package pacer_pkg;
  localparam int WORD_W  = 16;
  localparam int PRE_W   = 4;
  localparam int DIV_W   = 8;
  localparam int PRE_LSB = 8;
  localparam int CNT_W   = (1 << PRE_W) - 1;
  localparam logic [WORD_W-1:0] RESET_WORD = 16'hF000;

  // last prescaler state for a code: ratio-1, with codes 0 and 1 both ratio 1
  function automatic logic [CNT_W-1:0] pre_limit(input logic [PRE_W-1:0] code);
    logic [CNT_W:0] r;
    if (code <= 1) r = (CNT_W+1)'(1);
    else           r = (CNT_W+1)'(1) << code;
    return CNT_W'(r - (CNT_W+1)'(1));
  endfunction

  // the stored field is 255-N, which equals its bitwise complement
  function automatic logic [DIV_W-1:0] div_count(input logic [DIV_W-1:0] field);
    return ~field;
  endfunction
endpackage

// File: rtl/pacer_ctrl_reg.sv
module pacer_ctrl_reg
  import pacer_pkg::*;
#(
  parameter int W = WORD_W,
  parameter logic [W-1:0] INIT = RESET_WORD
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] word
);
  always_ff @(posedge clk) begin
    if (!rst_n)  word <= INIT;
    else if (we) word <= wdata;
  end

  assert_readback_R2: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (word == $past(wdata)));
endmodule

// File: rtl/pacer_prescaler.sv
module pacer_prescaler
  import pacer_pkg::*;
#(
  parameter int CW = PRE_W,
  parameter int NW = CNT_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          run,
  input  logic          ref_stb,
  input  logic [CW-1:0] code,
  output logic          pre_tick
);
  logic [NW-1:0] cnt;
  logic [NW-1:0] limit;
  logic          step;

  assign limit    = pre_limit(code);
  assign step     = run & ref_stb & ~restart;
  assign pre_tick = step & (cnt == limit);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) cnt <= '0;
    else if (step)         cnt <= (cnt == limit) ? '0 : cnt + 1'b1;
  end

  assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= limit);
  assert_pre_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !restart) |=> $stable(cnt));
endmodule

// File: rtl/pacer_divider.sv
module pacer_divider
  import pacer_pkg::*;
#(
  parameter int DW = DIV_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          pre_tick,
  input  logic [DW-1:0] n_val,
  output logic          tick
);
  logic [DW-1:0] cnt;
  logic          armed;
  logic          fire;

  assign armed = (n_val != '0);
  assign fire  = pre_tick & armed & (cnt == n_val - 1'b1);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      cnt  <= '0;
      tick <= 1'b0;
    end else begin
      tick <= fire;
      if (pre_tick && armed) cnt <= fire ? '0 : cnt + 1'b1;
    end
  end

  assert_div_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt < n_val) || (cnt == '0));
  assert_zero_inhibits_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (n_val == '0) |=> !tick);
  assert_tick_needs_step_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> $past(pre_tick));
endmodule

// File: rtl/pacer_div_top.sv
module pacer_div_top
  import pacer_pkg::*;
#(
  parameter int W  = WORD_W,
  parameter int PW = PRE_W,
  parameter int DW = DIV_W,
  parameter int PL = PRE_LSB
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         ctrl_we,
  input  logic [W-1:0] ctrl_wdata,
  output logic [W-1:0] ctrl_rdata,
  input  logic         ref_stb,
  input  logic         run_en,
  output logic         tick_o
);
  localparam int NW = (1 << PW) - 1;

  logic [W-1:0]  word;
  logic [PW-1:0] pre_code;
  logic [DW-1:0] n_val;
  logic          pre_tick;

  assign pre_code   = word[PL +: PW];
  assign n_val      = div_count(word[DW-1:0]);
  assign ctrl_rdata = word;

  pacer_ctrl_reg #(.W(W), .INIT(RESET_WORD)) u_reg (
    .clk(clk), .rst_n(rst_n), .we(ctrl_we), .wdata(ctrl_wdata), .word(word)
  );

  pacer_prescaler #(.CW(PW), .NW(NW)) u_pre (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_we), .run(run_en),
    .ref_stb(ref_stb), .code(pre_code), .pre_tick(pre_tick)
  );

  pacer_divider #(.DW(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .restart(ctrl_we), .pre_tick(pre_tick),
    .n_val(n_val), .tick(tick_o)
  );

  assert_idle_no_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |=> !tick_o);
  assert_write_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    ctrl_we |=> !tick_o);
  assert_tick_after_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
    tick_o |-> $past(ref_stb && run_en));
endmodule

// File: tb/tb_pacer_div_top.sv
module tb_pacer_div_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ctrl_we = 1'b0;
  logic [15:0] ctrl_wdata = '0;
  logic [15:0] ctrl_rdata;
  logic        ref_stb = 1'b0;
  logic        run_en = 1'b1;
  logic        tick_o;

  int compared = 0;
  int mismatched = 0;

  always #4 clk = ~clk;

  pacer_div_top dut (
    .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
    .ctrl_rdata(ctrl_rdata), .ref_stb(ref_stb), .run_en(run_en), .tick_o(tick_o)
  );

  function automatic int ratio_of(input int code);
    return (code < 2) ? 1 : (1 << code);
  endfunction

  function automatic logic [15:0] word_of(input int code, input int n);
    return {4'h0, 4'(code), 8'(255 - n)};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic write_word(input logic [15:0] w);
    @(negedge clk) ctrl_we = 1'b1; ctrl_wdata = w;
    @(negedge clk) ctrl_we = 1'b0;
  endtask

  // one strobe; t1 = tick in the cycle after it, t2 = tick one cycle later
  task automatic strobe(output logic t1, output logic t2);
    @(negedge clk) ref_stb = 1'b1;
    @(negedge clk) ref_stb = 1'b0; t1 = tick_o;
    @(negedge clk) t2 = tick_o;
  endtask

  // R3 R4 R5 R9: tick position sweep over several periods
  task automatic sweep(input int code, input int n, input int periods);
    int per;
    int bad_at;
    logic t1, t2;
    bit t2_bad;
    per = n * ratio_of(code);
    bad_at = -1;
    t2_bad = 0;
    write_word(word_of(code, n));
    for (int s = 1; s <= per * periods; s++) begin
      strobe(t1, t2);
      if (bad_at < 0 && (t1 !== ((s % per) == 0))) bad_at = s;
      if (t2 !== 1'b0) t2_bad = 1;
    end
    check(bad_at < 0, $sformatf("R3/R4 code=%0d n=%0d first bad strobe", code, n), bad_at, -1);
    check(!t2_bad, $sformatf("R5 single-cycle tick code=%0d n=%0d", code, n), int'(t2_bad), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ctrl_rdata == 16'hF000, "R1 reset word", ctrl_rdata, 16'hF000);
    check(ctrl_rdata[15:8] == 8'hF0, "R1 reset upper byte", ctrl_rdata[15:8], 8'hF0);
    check(tick_o == 1'b0, "R1 tick low after reset", tick_o, 0);

    write_word(16'hA5C3);
    check(ctrl_rdata == 16'hA5C3, "R2 read-back", ctrl_rdata, 16'hA5C3);
    write_word(16'h3F00);
    check(ctrl_rdata == 16'h3F00, "R2 read-back second word", ctrl_rdata, 16'h3F00);

    for (int c = 0; c <= 5; c++) begin
      sweep(c, 1, 2);
      sweep(c, 2, 2);
      sweep(c, 3, 2);
      sweep(c, 5, 2);
    end
    sweep(0, 255, 2);
    sweep(8, 2, 1);
    sweep(15, 1, 1);

    // R6: rewrite in mid-period restarts the count
    begin
      logic t1, t2;
      int first;
      first = -1;
      write_word(word_of(0, 5));
      for (int s = 0; s < 3; s++) strobe(t1, t2);
      write_word(word_of(0, 5));
      check(tick_o == 1'b0, "R6 tick low after write", tick_o, 0);
      for (int s = 1; s <= 6; s++) begin
        strobe(t1, t2);
        if (t1 && first < 0) first = s;
      end
      check(first == 5, "R6 first tick after restart", first, 5);
    end

    // R7: run low holds counters and blocks ticks
    begin
      logic t1, t2;
      bit any;
      int first;
      any = 0;
      first = -1;
      write_word(word_of(0, 4));
      strobe(t1, t2);
      strobe(t1, t2);
      @(negedge clk) run_en = 1'b0;
      for (int s = 0; s < 9; s++) begin
        strobe(t1, t2);
        if (t1 || t2) any = 1;
      end
      check(!any, "R7 no tick while run low", int'(any), 0);
      @(negedge clk) run_en = 1'b1;
      for (int s = 1; s <= 4; s++) begin
        strobe(t1, t2);
        if (t1 && first < 0) first = s;
      end
      check(first == 2, "R7 count resumes from held position", first, 2);
    end

    // R8: N = 0 inhibits ticks
    begin
      logic t1, t2;
      int seen;
      seen = 0;
      write_word(16'h00FF);
      for (int s = 0; s < 600; s++) begin
        strobe(t1, t2);
        if (t1 || t2) seen++;
      end
      write_word(16'h03FF);
      for (int s = 0; s < 100; s++) begin
        strobe(t1, t2);
        if (t1 || t2) seen++;
      end
      check(seen == 0, "R8 zero count gives no ticks", seen, 0);
    end

    // R9: clock cycles without strobe do not advance
    begin
      int seen;
      seen = 0;
      write_word(word_of(0, 1));
      for (int k = 0; k < 200; k++) begin
        @(negedge clk);
        if (tick_o) seen++;
      end
      check(seen == 0, "R9 no strobes no ticks", seen, 0);
    end

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=hang expected=finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule